// File: doc/BRIEF.md
# Asynchronous SRAM Word Controller with Byte Lanes

This block is a synchronous front end for an external asynchronous static RAM of 32K sixteen-bit words. A user issues one word-wide read or write at a time. The request carries an address, write data and a two-bit lane mask. The controller runs the memory strobes through four phases: idle, setup, active and recover. Each phase lasts a number of clock cycles set by a parameter, so the memory's pulse-width, setup and hold limits are met. The controller owns the direction of the shared data bus. It drives the bus only while a write is being set up and performed. During that time the output enable stays high, so the memory never drives against it.

Bit 0 of the lane mask selects the low byte (data bits 7:0), which is qualified by `memLbN`. Bit 1 selects the high byte (bits 15:8), which is qualified by `memUbN`. A completed transfer is signalled by a one-cycle `done` pulse. For reads, `rdData` holds the returned word, and any lane left out of the mask reads as zero.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset, `memCeN`, `memWeN`, `memOeN`, `memLbN` and `memUbN` are all high, `busy` and `done` are low and `rdData` is zero.
- R2: A request is accepted only while `busy` is low; `reqValid` raised during a transfer has no effect on the memory or on the number of `done` pulses.
- R3: In a write, the low byte (bits 7:0) reaches the memory only when mask bit 0 is 1, and the high byte (bits 15:8) only when mask bit 1 is 1; the other lane of the addressed word keeps its old value.
- R4: A write holds `memWeN` low for exactly WE_CYC cycles (default 1), with `memCeN` low and `memOeN` high in each of those cycles.
- R5: A read holds `memOeN` low for exactly RD_CYC cycles (default 2), with `memCeN` low and `memWeN` high, and returns the addressed word on `rdData` when `done` is high.
- R6: On a read, a lane whose mask bit is 0 is returned as zero, and its byte enable stays high for the whole transfer.
- R7: `busy` is high for SETUP_CYC + active cycles + REC_CYC cycles after acceptance (3 for a default write, 4 for a default read). `done` rises in the first cycle after `busy` falls and lasts exactly one cycle.
- R8: The controller drives `memData` only during the setup and active phases of a write. During the write pulse the bus carries the request data. A later read returns the memory's own contents.
- R9: During the setup cycle the byte enables of selected lanes are low while `memCeN`, `memWeN` and `memOeN` are high. `memAddr` holds the full 15-bit request address, unchanged, while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 15 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane select: bit 0 low byte, bit 1 high byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 16 | Read result, zero in unselected lanes |
| memAddr | output | 15 | Memory address |
| memData | inout | 16 | Memory data bus |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memOeN | output | 1 | Output enable, active low |
| memLbN | output | 1 | Low byte enable, active low |
| memUbN | output | 1 | High byte enable, active low |

## Verification
The hardest case to reach from the ports is a second request that arrives while a transfer is still running. The user is meant to wait for `busy`, so this case only appears if the stimulus deliberately breaks that rule. The bench starts a write and, during the cycles that follow, raises `reqValid` with a write to a different address. It then inspects the memory model for that second address and counts the `done` pulses. A behavioural memory attached to the bus commits a lane only while chip enable, write enable and that lane's enable are all low. A lane-mask error therefore shows up directly as corrupted bytes in the model.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ACTIVE,
    ST_RECOVER
  } ctrl_state_t;

  // Strobe bundle from control to datapath
  typedef struct packed {
    logic busy;     // transfer in flight
    logic load;     // latch request fields
    logic ceN;
    logic weN;
    logic oeN;
    logic laneEn;   // byte enables may follow the stored mask
    logic drive;    // controller owns the data bus
    logic capture;  // sample read data this cycle
  } ctrl_strobes_t;

endpackage

// File: rtl/sram_lane_fsm.sv
module sram_lane_fsm
  import sram_lane_pkg::*;
#(
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 1,
  parameter int RD_CYC    = 2,
  parameter int REC_CYC   = 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  output ctrl_strobes_t strobes,
  output logic          done
);

  localparam int MAX_A   = (WE_CYC > RD_CYC) ? WE_CYC : RD_CYC;
  localparam int MAX_B   = (SETUP_CYC > REC_CYC) ? SETUP_CYC : REC_CYC;
  localparam int MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] WE_LAST    = CNT_W'(WE_CYC - 1);
  localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LAST   = CNT_W'(REC_CYC - 1);

  ctrl_state_t      state;
  logic [CNT_W-1:0] phaseCnt;
  logic             isWrite;
  logic [CNT_W-1:0] activeLast;

  assign activeLast = isWrite ? WE_LAST : RD_LAST;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      isWrite  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            isWrite  <= reqWrite;
            phaseCnt <= '0;
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (phaseCnt == SETUP_LAST) begin
            phaseCnt <= '0;
            state    <= ST_ACTIVE;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_ACTIVE: begin
          if (phaseCnt == activeLast) begin
            phaseCnt <= '0;
            state    <= ST_RECOVER;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_RECOVER: begin
          if (phaseCnt == REC_LAST) begin
            phaseCnt <= '0;
            state    <= ST_IDLE;
            done     <= 1'b1;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.busy    = (state != ST_IDLE);
    strobes.load    = (state == ST_IDLE) && reqValid;
    strobes.ceN     = (state != ST_ACTIVE);
    strobes.weN     = !((state == ST_ACTIVE) && isWrite);
    strobes.oeN     = !((state == ST_ACTIVE) && !isWrite);
    strobes.laneEn  = (state == ST_SETUP) || (state == ST_ACTIVE);
    strobes.drive   = isWrite && ((state == ST_SETUP) || (state == ST_ACTIVE));
    strobes.capture = (state == ST_ACTIVE) && !isWrite && (phaseCnt == RD_LAST);
  end

  // R4: write pulse never overlaps output enable
  p_we_oe_excl_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.weN |-> strobes.oeN);
  // R4: write pulse only inside chip select
  p_we_in_ce_r4: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.weN |-> !strobes.ceN);
  // R7: done is a single-cycle pulse
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R7: done follows the end of busy
  p_done_after_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!strobes.busy && $past(strobes.busy)));
  // R2: a request in flight keeps busy high into the next cycle
  p_accept_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.busy && reqValid) |=> strobes.busy);

endmodule

// File: rtl/sram_lane_datapath.sv
module sram_lane_datapath
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctrl_strobes_t             strobes,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [LANES*LANE_W-1:0]   reqWdata,
  input  logic [LANES-1:0]          reqMask,
  output logic [LANES*LANE_W-1:0]   rdData,
  output logic [ADDR_W-1:0]         memAddr,
  inout  wire  [LANES*LANE_W-1:0]   memData,
  output logic [LANES-1:0]          laneN
);

  logic [LANES*LANE_W-1:0] wdataQ;
  logic [LANES-1:0]        maskQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memAddr <= '0;
      wdataQ  <= '0;
      maskQ   <= '0;
    end else if (strobes.load) begin
      memAddr <= reqAddr;
      wdataQ  <= reqWdata;
      maskQ   <= reqMask;
    end
  end

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign laneN[gl] = !(strobes.laneEn && maskQ[gl]);
    assign memData[gl*LANE_W +: LANE_W] =
      strobes.drive ? wdataQ[gl*LANE_W +: LANE_W] : {LANE_W{1'bz}};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        rdData[gl*LANE_W +: LANE_W] <= '0;
      end else if (strobes.capture) begin
        rdData[gl*LANE_W +: LANE_W] <=
          maskQ[gl] ? memData[gl*LANE_W +: LANE_W] : {LANE_W{1'b0}};
      end
    end
  end

  // R8: the bus driver is never on while the memory output is enabled
  p_drive_no_oe_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.drive |-> strobes.oeN);
  // R9: address held while a transfer runs
  p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.busy && $past(strobes.busy)) |-> $stable(memAddr));
  // R6: lanes released outside setup and active phases
  p_lanes_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.laneEn |-> (laneN == {LANES{1'b1}}));

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int LANE_W    = 8,
  parameter int LANES     = 2,
  parameter int SETUP_CYC = 1,
  parameter int WE_CYC    = 1,
  parameter int RD_CYC    = 2,
  parameter int REC_CYC   = 1,
  localparam int DATA_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  inout  wire  [DATA_W-1:0] memData,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memOeN,
  output logic              memLbN,
  output logic              memUbN
);

  ctrl_strobes_t   strobes;
  logic [LANES-1:0] laneN;

  sram_lane_fsm #(
    .SETUP_CYC(SETUP_CYC),
    .WE_CYC   (WE_CYC),
    .RD_CYC   (RD_CYC),
    .REC_CYC  (REC_CYC)
  ) fsm_i (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqWrite(reqWrite),
    .strobes (strobes),
    .done    (done)
  );

  sram_lane_datapath #(
    .ADDR_W(ADDR_W),
    .LANE_W(LANE_W),
    .LANES (LANES)
  ) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .reqAddr (reqAddr),
    .reqWdata(reqWdata),
    .reqMask (reqMask),
    .rdData  (rdData),
    .memAddr (memAddr),
    .memData (memData),
    .laneN   (laneN)
  );

  assign busy   = strobes.busy;
  assign memCeN = strobes.ceN;
  assign memWeN = strobes.weN;
  assign memOeN = strobes.oeN;
  assign memLbN = laneN[0];
  assign memUbN = laneN[LANES-1];

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [14:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic        busy, done;
  logic [15:0] rdData;
  logic [14:0] memAddr;
  wire  [15:0] memData;
  logic        memCeN, memWeN, memOeN, memLbN, memUbN;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sram_lane_ctrl dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .busy(busy), .done(done), .rdData(rdData), .memAddr(memAddr),
    .memData(memData), .memCeN(memCeN), .memWeN(memWeN), .memOeN(memOeN),
    .memLbN(memLbN), .memUbN(memUbN)
  );

  // Behavioural memory, indexed by the low address byte
  logic [15:0] mem [0:255];
  logic readLo, readHi;
  assign readLo = !memCeN && !memOeN && memWeN && !memLbN;
  assign readHi = !memCeN && !memOeN && memWeN && !memUbN;
  assign memData[7:0]  = readLo ? mem[memAddr[7:0]][7:0]  : 8'hzz;
  assign memData[15:8] = readHi ? mem[memAddr[7:0]][15:8] : 8'hzz;

  always @(posedge clk) begin
    if (!memCeN && !memWeN) begin
      if (!memLbN) mem[memAddr[7:0]][7:0]  <= memData[7:0];
      if (!memUbN) mem[memAddr[7:0]][15:8] <= memData[15:8];
    end
  end

  // Watchdog
  int wdCnt = 0;
  always @(posedge clk) begin
    wdCnt <= wdCnt + 1;
    if (wdCnt > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 20000", wdCnt);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-transfer observations
  int busyCyc, weLow, oeLow, weOeBad, weCeBad, laneLow, addrBad, donePulses;
  logic firstCe, firstWe, firstOe, firstLb, firstUb, doneAfter;
  logic [15:0] busAtWe, rdCaught;

  task automatic runOp(input logic wr, input logic [14:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit intrude);
    busyCyc = 0; weLow = 0; oeLow = 0; weOeBad = 0; weCeBad = 0;
    laneLow = 0; addrBad = 0; donePulses = 0; busAtWe = 'x; rdCaught = 'x;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (intrude) begin
        reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 15'h0055;
        reqWdata = 16'hDEAD; reqMask = 2'b11;
      end else begin
        reqValid = 1'b0;
      end
      if (i == 0) begin
        firstCe = memCeN; firstWe = memWeN; firstOe = memOeN;
        firstLb = memLbN; firstUb = memUbN;
      end
      if (busy) busyCyc++;
      if (busy && memAddr != a) addrBad++;
      if (!memWeN) begin weLow++; busAtWe = memData; end
      if (!memWeN && !memOeN) weOeBad++;
      if (!memWeN && memCeN) weCeBad++;
      if (!memOeN) oeLow++;
      if (!memLbN || !memUbN) laneLow++;
      if (done) begin
        donePulses++;
        rdCaught = rdData;
        reqValid = 1'b0;
        break;
      end
    end
    @(negedge clk);
    doneAfter = done;
  endtask

  task automatic testReset();
    chk("R1 ceN", memCeN, 1); chk("R1 weN", memWeN, 1); chk("R1 oeN", memOeN, 1);
    chk("R1 lbN", memLbN, 1); chk("R1 ubN", memUbN, 1);
    chk("R1 busy", busy, 0); chk("R1 done", done, 0); chk("R1 rdData", rdData, 0);
  endtask

  task automatic testFullWrite();
    runOp(1'b1, 15'h0010, 16'hA55A, 2'b11, 1'b0);
    chk("R4 we cycles", weLow, 1);
    chk("R4 oe during we", weOeBad, 0);
    chk("R4 ce during we", weCeBad, 0);
    chk("R7 busy cycles write", busyCyc, 3);
    chk("R7 done single", doneAfter, 0);
    chk("R8 bus during we", busAtWe, 16'hA55A);
    chk("R3 full write", mem[8'h10], 16'hA55A);
    chk("R9 setup ce", firstCe, 1); chk("R9 setup we", firstWe, 1);
    chk("R9 setup oe", firstOe, 1);
    chk("R9 setup lanes", {firstUb, firstLb}, 2'b00);
    chk("R9 addr stable", addrBad, 0);
  endtask

  task automatic testLaneWrites();
    runOp(1'b1, 15'h0010, 16'h1234, 2'b01, 1'b0);
    chk("R3 low lane only", mem[8'h10], 16'hA534);
    chk("R9 setup lanes low", {firstUb, firstLb}, 2'b10);
    runOp(1'b1, 15'h0010, 16'hBEEF, 2'b10, 1'b0);
    chk("R3 high lane only", mem[8'h10], 16'hBE34);
  endtask

  task automatic testReads();
    runOp(1'b0, 15'h0010, 16'h0000, 2'b11, 1'b0);
    chk("R5 read data", rdCaught, 16'hBE34);
    chk("R5 oe cycles", oeLow, 2);
    chk("R5 no we", weLow, 0);
    chk("R7 busy cycles read", busyCyc, 4);
    chk("R8 read sees memory", rdData, 16'hBE34);
    runOp(1'b0, 15'h0010, 16'h0000, 2'b01, 1'b0);
    chk("R6 low lane read", rdCaught, 16'h0034);
    runOp(1'b0, 15'h0010, 16'h0000, 2'b10, 1'b0);
    chk("R6 high lane read", rdCaught, 16'hBE00);
    runOp(1'b0, 15'h0010, 16'h0000, 2'b00, 1'b0);
    chk("R6 no lane read", rdCaught, 16'h0000);
    chk("R6 lanes stay high", laneLow, 0);
  endtask

  task automatic testBusyIgnore();
    mem[8'h55] = 16'h0F0F;
    runOp(1'b1, 15'h0020, 16'h7788, 2'b11, 1'b1);
    chk("R2 target written", mem[8'h20], 16'h7788);
    chk("R2 intruder ignored", mem[8'h55], 16'h0F0F);
    chk("R2 single done", donePulses, 1);
    chk("R2 busy cycles", busyCyc, 3);
  endtask

  task automatic testTopAddress();
    runOp(1'b1, 15'h7FFF, 16'hC3C3, 2'b11, 1'b0);
    chk("R9 full address", addrBad, 0);
    runOp(1'b0, 15'h7FFF, 16'h0000, 2'b11, 1'b0);
    chk("R5 top address read", rdCaught, 16'hC3C3);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testFullWrite();
    testLaneWrites();
    testReads();
    testBusyIgnore();
    testTopAddress();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule